// File: doc/BRIEF.md
# Register-Controlled SPI Master Channel

This block is one SPI master channel that software drives through six word-wide registers. The registers set up the frame, start it and report on it. Software chooses the clock idle level and the sampling edge, a power-of-two clock divide, a word length from 1 to 32 bits, and the active level of the chip select. It also chooses one of three traffic modes: full duplex, transmit-only or receive-only. Words are shifted MSB first on SCK and MOSI, and MISO is sampled into a receive holding register.

Software raises a force bit to hold the chip select across a burst of words. Without that bit the select is active only while a word is shifting. In receive-only mode, one write to the transmit register starts reception. After that, every read of the receive register starts the next word, so software never writes dummy data again. A self-clearing soft reset returns every register to its power-up value.

Register addresses are: 0 configuration, 1 control, 2 status, 3 transmit data, 4 receive data, 5 soft reset.

Top module: `spi_master_chan`

## Requirements
- R1: After reset the status register reads 0xA (bit1 transmit-empty = 1, bit3 reset-done = 1, bit0 receive-full = 0, bit2 end-of-transfer = 0). Configuration reads 0, SCK is 0 and the chip select is 0.
- R2: Configuration bit1 sets the SCK idle level and bit0 the data phase. With bit0 = 0, data changes on the trailing edge and is sampled on the leading edge. With bit0 = 1, data changes on the leading edge and is sampled on the trailing edge. Data goes out MSB first, and a word looped back from MOSI to MISO is received intact in all four modes.
- R3: Configuration bits [5:2] hold N, and values above 12 act as 12. Each SCK half-period lasts 2^N clock cycles. A word of W bits produces 2W SCK edges, and end-of-transfer appears 1 + 2·W·2^N cycles after the transmit write of an idle channel.
- R4: Configuration bits [11:7] hold the word length minus one (1 to 32 bits). The received word is right-aligned, and its upper bits are zero.
- R5: Configuration bit6 sets the chip-select polarity: 1 means active low, 0 means active high. Without force, the select is active only while a word is shifting on an enabled channel.
- R6: While the channel is enabled and configuration bit14 (force) is set, the chip select stays active, including across consecutive words. Clearing the bit deasserts it.
- R7: Status bit1 (transmit-empty) clears on a transmit write and sets when the word is loaded into the shifter. Status bit0 (receive-full) sets when a word completes and clears on a receive read. A receive read on the same edge as a word completion leaves bit0 set and returns the previous word.
- R8: Status bit2 (end-of-transfer) clears when a word starts. It sets when a word ends only if no transmit data is pending, so back-to-back words produce one end-of-transfer.
- R9: Configuration bits [13:12] select the traffic mode: 0 full duplex, 1 receive-only, 2 or 3 transmit-only. In transmit-only mode, receive-full stays 0 and the receive register keeps its old value.
- R10: In receive-only mode, a single transmit write starts the first word and leaves transmit-empty at 1. Each receive read starts the next word, and no word starts while receive-full is set.
- R11: Writing 1 to bit0 of address 5 clears reset-done for one cycle. On the next cycle every register is back at its reset value.
- R12: Control bit0 enables the channel. While it is 0, no word starts. Clearing it aborts a word in flight and stops receive-only reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | reference clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_addr | input | 3 | register address |
| bus_wr | input | 1 | register write strobe |
| bus_rd | input | 1 | register read strobe (side effect on receive data only) |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational from bus_addr |
| spi_sck | output | 1 | serial clock |
| spi_mosi | output | 1 | serial data out |
| spi_miso | input | 1 | serial data in |
| spi_cs | output | 1 | chip select, polarity per configuration |

## Verification
Two events can land on the same edge: a software read of the receive register and the completion of the next word. The bench places a receive read exactly on the cycle the second word finishes, which it counts from the transmit write using the divider and word length. It then judges the result in three ways. The read must return the first word. Receive-full must still be set afterwards. A further read must return the second word. The back-to-back test covers a second collision, a transmit write while the shifter is busy. The bench confirms that no end-of-transfer shows between the two words and that the chip select never drops.

// File: rtl/spi_master_chan.sv
module spi_master_chan #(
  parameter int DW     = 32,
  parameter int MAXDIV = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          spi_sck,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic          spi_cs
);
  localparam int WLW = $clog2(DW);
  localparam int CW  = MAXDIV;

  logic [15:0]    cfg;
  logic           en, txs, rxs, eot, busy, run_rx, srst, half, sck_q, mosi_q;
  logic [DW-1:0]  txbuf, rxbuf, tsh, rsh;
  logic [CW-1:0]  cnt;
  logic [WLW-1:0] bitn;

  wire           cpha    = cfg[0];
  wire           cpol    = cfg[1];
  wire           cspol   = cfg[6];
  wire [WLW-1:0] wl      = cfg[7 +: WLW];
  wire           rx_only = cfg[13:12] == 2'd1;
  wire           tx_only = cfg[13];
  wire           frc     = cfg[14];

  wire [3:0]    dvc  = (cfg[5:2] > 4'(MAXDIV)) ? 4'(MAXDIV) : cfg[5:2];
  wire [CW-1:0] hlim = CW'((32'd1 << dvc) - 32'd1);

  wire wr_cfg = bus_wr && bus_addr == 3'd0;
  wire wr_ctl = bus_wr && bus_addr == 3'd1;
  wire wr_tx  = bus_wr && bus_addr == 3'd3;
  wire wr_sys = bus_wr && bus_addr == 3'd5;
  wire rd_rx  = bus_rd && bus_addr == 3'd4;

  wire start  = en && !busy && (rx_only ? (run_rx && !rxs) : !txs);
  wire edge_t = busy && cnt == hlim;
  wire lead   = edge_t && !half;
  wire trail  = edge_t && half;
  wire last   = trail && bitn == wl;
  wire smp    = cpha ? trail : lead;
  wire drv    = cpha ? lead : (trail && !last);
  wire [DW-1:0] rsh_in = {rsh[DW-2:0], spi_miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; en <= 1'b0; txbuf <= '0; rxbuf <= '0; tsh <= '0; rsh <= '0;
      txs <= 1'b1; rxs <= 1'b0; eot <= 1'b0; busy <= 1'b0; run_rx <= 1'b0;
      cnt <= '0; half <= 1'b0; bitn <= '0; sck_q <= 1'b0; mosi_q <= 1'b0; srst <= 1'b0;
    end else if (srst) begin
      cfg <= '0; en <= 1'b0; txbuf <= '0; rxbuf <= '0; tsh <= '0; rsh <= '0;
      txs <= 1'b1; rxs <= 1'b0; eot <= 1'b0; busy <= 1'b0; run_rx <= 1'b0;
      cnt <= '0; half <= 1'b0; bitn <= '0; sck_q <= 1'b0; mosi_q <= 1'b0; srst <= 1'b0;
    end else begin
      srst <= wr_sys && bus_wdata[0];
      if (wr_cfg) cfg <= bus_wdata[15:0];
      if (wr_ctl) en <= bus_wdata[0];
      if (rd_rx) rxs <= 1'b0;

      if (start) begin
        busy  <= 1'b1;
        cnt   <= '0;
        half  <= 1'b0;
        bitn  <= '0;
        rsh   <= '0;
        eot   <= 1'b0;
        sck_q <= cpol;
        if (cpha) tsh <= txbuf;
        else begin
          tsh    <= txbuf << 1;
          mosi_q <= txbuf[wl];
        end
        if (!rx_only) txs <= 1'b1;
      end else if (busy) begin
        cnt <= edge_t ? '0 : CW'(cnt + 1'b1);
        if (edge_t) begin
          sck_q <= ~sck_q;
          half  <= ~half;
        end
        if (drv) begin
          mosi_q <= tsh[wl];
          tsh    <= tsh << 1;
        end
        if (smp) rsh <= rsh_in;
        if (trail && !last) bitn <= bitn + 1'b1;
        if (last) begin
          busy <= 1'b0;
          eot  <= rx_only ? 1'b1 : (txs && !wr_tx);
          if (!tx_only) begin
            rxbuf <= cpha ? rsh_in : rsh;
            rxs   <= 1'b1;
          end
        end
      end

      if (wr_tx) begin
        txbuf <= bus_wdata[DW-1:0];
        if (rx_only) run_rx <= 1'b1;
        else txs <= 1'b0;
      end
      if (wr_ctl && !bus_wdata[0]) begin
        busy   <= 1'b0;
        run_rx <= 1'b0;
      end
    end
  end

  wire cs_act = en && (frc || busy);
  assign spi_cs   = cspol ? ~cs_act : cs_act;
  assign spi_sck  = busy ? sck_q : cpol;
  assign spi_mosi = mosi_q;

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {16'b0, cfg};
      3'd1:    bus_rdata = {31'b0, en};
      3'd2:    bus_rdata = {28'b0, ~srst, eot, txs, rxs};
      3'd3:    bus_rdata = 32'(txbuf);
      3'd4:    bus_rdata = 32'(rxbuf);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_master_chan_chk.sv
module spi_master_chan_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   cfg,
  input logic          en,
  input logic          busy,
  input logic          eot,
  input logic          txs,
  input logic          rxs,
  input logic          srst,
  input logic          wr_tx,
  input logic          rx_only,
  input logic          tx_only,
  input logic          spi_cs,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] hlim
);
  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) busy |-> cnt <= hlim); // R3
  AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cfg[14] && $past(en && cfg[14]) && $stable(cfg)) |-> $stable(spi_cs)); // R6
  AST_TXS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (wr_tx && !rx_only && !srst) |=> !txs); // R7
  AST_EOT_AT_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !eot); // R8
  AST_TXONLY_NO_RX: assert property (@(posedge clk) disable iff (!rst_n) (tx_only && !rxs) |=> !rxs); // R9
  AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n) srst |=> (cfg == 16'h0 && !en && txs && !rxs)); // R11
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !busy); // R12
endmodule

bind spi_master_chan spi_master_chan_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .en(en), .busy(busy), .eot(eot), .txs(txs),
  .rxs(rxs), .srst(srst), .wr_tx(wr_tx), .rx_only(rx_only), .tx_only(tx_only),
  .spi_cs(spi_cs), .cnt(cnt), .hlim(hlim)
);

// File: tb/spi_master_chan_tb.sv
module spi_master_chan_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, inv = 1'b0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         sck, mosi, cs;
  wire         miso = mosi ^ inv;

  spi_master_chan dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_cs(cs)
  );

  localparam logic [2:0] A_CFG = 3'd0, A_CTL = 3'd1, A_STA = 3'd2, A_TX = 3'd3, A_RX = 3'd4, A_SYS = 3'd5;

  // {cpol,cpha}[43:42] div[41:38] wlen-1[37:33] inv[32] tx[31:0]
  localparam logic [43:0] VECS [7] = '{
    {2'd0, 4'd0,  5'd7,  1'b0, 32'h000000A5},
    {2'd1, 4'd1,  5'd7,  1'b1, 32'h0000003C},
    {2'd2, 4'd2,  5'd15, 1'b0, 32'h0000BEEF},
    {2'd3, 4'd0,  5'd31, 1'b1, 32'h12345678},
    {2'd0, 4'd15, 5'd0,  1'b0, 32'h00000001},
    {2'd3, 4'd3,  5'd4,  1'b0, 32'h00000015},
    {2'd1, 4'd12, 5'd1,  1'b1, 32'h00000002}
  };

  int checks = 0, errors = 0;
  int mon_edges = 0;
  logic [31:0] mon_sh = '0;
  logic mon_on = 1'b0, b_cpol = 1'b0, b_cpha = 1'b0, cs_watch = 1'b0, cs_bad = 1'b0;

  always @(sck) if (mon_on) begin
    mon_edges++;
    if ((sck != b_cpol) ^ b_cpha) mon_sh = {mon_sh[30:0], mosi};
  end
  always @(negedge clk) if (cs_watch && cs !== 1'b0) cs_bad = 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #2 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic wait_eot(output int k);
    logic [31:0] s;
    k = 0;
    do begin
      @(negedge clk); k++;
      peek(A_STA, s);
    end while (!s[2]);
  endtask

  task automatic mon_start(input logic cp, input logic ch);
    b_cpol = cp; b_cpha = ch; mon_edges = 0; mon_sh = '0; mon_on = 1'b1;
  endtask

  function automatic logic [31:0] mkcfg(input logic frc, input logic [1:0] trm, input logic [4:0] wl,
                                        input logic csp, input logic [3:0] dv, input logic cp, input logic ch);
    return {17'b0, frc, trm, wl, csp, dv, cp, ch};
  endfunction

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_up();
  end

  initial begin
    logic [31:0] d, d2;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(A_STA, d); chk("R1 status", d, 32'hA);
    peek(A_CFG, d); chk("R1 config", d, 32'h0);
    chk("R1 sck", {31'b0, sck}, 32'h0);
    chk("R1 cs", {31'b0, cs}, 32'h0);

    // R2 R3 R4: table of modes, dividers and word lengths
    wr_reg(A_CTL, 32'h1);
    for (int i = 0; i < 7; i++) begin
      logic [1:0]  md  = VECS[i][43:42];
      logic [3:0]  dv  = VECS[i][41:38];
      logic [4:0]  wl  = VECS[i][37:33];
      logic [31:0] tx  = VECS[i][31:0];
      logic [63:0] msk = (64'd1 << (wl + 1)) - 64'd1;
      int effd = (dv > 12) ? 12 : int'(dv);
      inv = VECS[i][32];
      wr_reg(A_CFG, mkcfg(1'b0, 2'd0, wl, 1'b0, dv, md[1], md[0]));
      mon_start(md[1], md[0]);
      wr_reg(A_TX, tx);
      wait_eot(k);
      chk("R3 word duration", k, 1 + 2 * (int'(wl) + 1) * (1 << effd));
      chk("R3 sck edges", mon_edges, 2 * (int'(wl) + 1));
      chk("R2 mosi bits", mon_sh, tx & msk[31:0]);
      rd_reg(A_RX, d);
      chk("R4 rx word", d, (tx ^ {32{inv}}) & msk[31:0]);
      mon_on = 1'b0;
    end
    inv = 1'b0;

    // R5 R6 chip select polarity and force
    wr_reg(A_CTL, 32'h0);
    wr_reg(A_CFG, mkcfg(1'b0, 2'd0, 5'd7, 1'b1, 4'd0, 1'b0, 1'b0));
    chk("R5 cs idle active-low", {31'b0, cs}, 32'h1);
    wr_reg(A_CTL, 32'h1);
    chk("R5 cs enabled idle", {31'b0, cs}, 32'h1);
    wr_reg(A_CFG, mkcfg(1'b1, 2'd0, 5'd7, 1'b1, 4'd0, 1'b0, 1'b0));
    chk("R6 cs forced", {31'b0, cs}, 32'h0);
    wr_reg(A_CFG, mkcfg(1'b0, 2'd0, 5'd7, 1'b1, 4'd0, 1'b0, 1'b0));
    chk("R6 cs released", {31'b0, cs}, 32'h1);
    wr_reg(A_TX, 32'h77);
    repeat (2) @(negedge clk);
    chk("R5 cs during word", {31'b0, cs}, 32'h0);
    wait_eot(k);
    chk("R5 cs after word", {31'b0, cs}, 32'h1);
    rd_reg(A_RX, d);

    // R8 R6 back-to-back words under force
    wr_reg(A_CFG, mkcfg(1'b1, 2'd0, 5'd7, 1'b1, 4'd0, 1'b0, 1'b0));
    mon_start(1'b0, 1'b0);
    cs_watch = 1'b1; cs_bad = 1'b0;
    wr_reg(A_TX, 32'hC3);
    do begin @(negedge clk); peek(A_STA, d); end while (!d[1]);
    wr_reg(A_TX, 32'h5E);
    wait_eot(k);
    chk("R8 one eot for two words", mon_edges, 32);
    chk("R8 both words shifted", {16'b0, mon_sh[15:0]}, 32'hC35E);
    chk("R6 cs held across words", {31'b0, cs_bad}, 32'h0);
    cs_watch = 1'b0; mon_on = 1'b0;
    rd_reg(A_RX, d);
    chk("R8 second word received", d, 32'h5E);

    // R7 receive read colliding with word completion
    wr_reg(A_CFG, mkcfg(1'b0, 2'd0, 5'd7, 1'b0, 4'd0, 1'b0, 1'b0));
    wr_reg(A_TX, 32'h11);
    wait_eot(k);
    wr_reg(A_TX, 32'h22);
    repeat (15) @(negedge clk);
    rd_reg(A_RX, d);
    chk("R7 colliding read returns old word", d, 32'h11);
    peek(A_STA, d);
    chk("R7 rxs kept on collision", d & 32'h1, 32'h1);
    rd_reg(A_RX, d);
    chk("R7 new word after collision", d, 32'h22);
    peek(A_STA, d);
    chk("R7 rxs cleared by read", d & 32'h1, 32'h0);

    // R12 disabled channel holds data; R7 txs clears on write
    wr_reg(A_CTL, 32'h0);
    mon_start(1'b0, 1'b0);
    wr_reg(A_TX, 32'h5A);
    repeat (50) @(negedge clk);
    chk("R12 no sck while disabled", mon_edges, 0);
    peek(A_STA, d);
    chk("R7 txs cleared by write", d & 32'h2, 32'h0);
    wr_reg(A_CTL, 32'h1);
    wait_eot(k);
    rd_reg(A_RX, d);
    chk("R12 word after enable", d, 32'h5A);
    mon_on = 1'b0;

    // R9 transmit-only
    wr_reg(A_CFG, mkcfg(1'b0, 2'd2, 5'd7, 1'b0, 4'd0, 1'b0, 1'b0));
    mon_start(1'b0, 1'b0);
    wr_reg(A_TX, 32'h33);
    wait_eot(k);
    peek(A_STA, d);
    chk("R9 rxs stays clear", d & 32'h1, 32'h0);
    peek(A_RX, d);
    chk("R9 rx register unchanged", d, 32'h5A);
    chk("R9 word transmitted", {24'b0, mon_sh[7:0]}, 32'h33);
    mon_on = 1'b0;

    // R10 receive-only continuous reception
    inv = 1'b1;
    wr_reg(A_CFG, mkcfg(1'b0, 2'd1, 5'd7, 1'b0, 4'd0, 1'b0, 1'b0));
    mon_start(1'b0, 1'b0);
    wr_reg(A_TX, 32'h0F);
    peek(A_STA, d);
    chk("R10 txs stays set", d & 32'h2, 32'h2);
    wait_eot(k);
    repeat (40) @(negedge clk);
    chk("R10 pauses while rxs set", mon_edges, 16);
    rd_reg(A_RX, d);
    chk("R10 first word", d, 32'hF0);
    wait_eot(k);
    rd_reg(A_RX, d2);
    chk("R10 second word without write", d2, 32'hF0);
    chk("R10 two words shifted", mon_edges >= 32 ? 32'd1 : 32'd0, 32'd1);
    wr_reg(A_CTL, 32'h0);
    repeat (30) @(negedge clk);
    peek(A_STA, d);
    chk("R12 disable stops reception", d & 32'h1, 32'h0);
    mon_on = 1'b0; inv = 1'b0;

    // R11 soft reset
    wr_reg(A_CFG, 32'h7FFF);
    wr_reg(A_CTL, 32'h1);
    wr_reg(A_SYS, 32'h1);
    peek(A_STA, d);
    chk("R11 reset-done low during reset", d & 32'h8, 32'h0);
    @(negedge clk);
    peek(A_STA, d); chk("R11 status default", d, 32'hA);
    peek(A_CFG, d); chk("R11 config default", d, 32'h0);
    peek(A_CTL, d); chk("R11 control default", d, 32'h0);

    finish_up();
  end
endmodule